// File: doc/BRIEF.md
# 64-bit Load/Store Address and Extension Unit

This unit executes the three memory instructions that the 64-bit integer base adds on top of the 32-bit one: an unsigned 32-bit word load, a 64-bit doubleword load and a 64-bit doubleword store. It takes one instruction word per cycle, with the values of its base register and its second source register. It decodes the instruction and adds the sign-extended 12-bit offset to the base, which gives the effective address. In the same cycle it drives a synchronous data memory port with an address, a write enable, eight byte strobes and 64 bits of write data.

Memory is little-endian on a 64-bit bus and returns read data one clock after the request. In that following cycle the unit forms the 64-bit write-back value and raises a register-write enable with the destination index. An access whose effective address is not aligned to its size is flagged in the request cycle. It then writes nothing to memory and nothing to the register file. Instruction words the unit does not recognise have no effect at all.

Top module: `lsu64_unit`

## Requirements
- R1: Only three encodings act. Opcode 0000011 with funct3 110 is the unsigned word load, and opcode 0000011 with funct3 011 is the doubleword load. Opcode 0100011 with funct3 011 is the doubleword store. Any other word, or any cycle with `req_valid` low, causes no memory write, zero strobes, no misaligned flag and no register write one cycle later.
- R2: For both loads, `mem_addr` equals `base_val` plus the 12-bit immediate in instruction bits [31:20], sign-extended to 64 bits, modulo 2^64. It is valid in the request cycle.
- R3: For the store, the immediate is {instr[31:25], instr[11:7]}, sign-extended from bit 11. It is added to `base_val` in the same way to give `mem_addr`.
- R4: The unsigned word load writes back the 32-bit little-endian word at the effective address, zero-extended to 64 bits. When address bit 2 is 0 the word is read-data bits [31:0], and when bit 2 is 1 it is bits [63:32].
- R5: The doubleword load writes back all 64 read-data bits unchanged.
- R6: An aligned store raises `mem_we` with `mem_be` = 8'hFF and `mem_wdata` = `src2_val` in the request cycle. A store never raises `wb_en`. Whenever `mem_we` is low, `mem_be` is 8'h00.
- R7: A load whose destination index (instr[11:7]) is zero never raises `wb_en`.
- R8: A doubleword access (load or store) with address bits [2:0] not all zero is misaligned, and so is a word load with address bits [1:0] not all zero. A misaligned access raises `misalign` in the request cycle, keeps `mem_we` low and is followed by no register write.
- R9: An aligned load with a nonzero destination raises `wb_en` exactly one cycle after its request. In that cycle `wb_idx` equals the destination index and `wb_data` holds the value of R4 or R5. When `wb_en` is low, `wb_idx` and `wb_data` are zero.
- R10: While `rst_n` is low and in the first cycle after it, `wb_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Value of the base (first source) register |
| src2_val | input | 64 | Value of the second source register (store data) |
| mem_addr | output | 64 | Effective byte address |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 8 | Byte strobes, one per data byte |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, one cycle after the request |
| misalign | output | 1 | Access misaligned for its size |
| wb_en | output | 1 | Register-file write enable |
| wb_idx | output | 5 | Register-file destination index |
| wb_data | output | 64 | Register-file write data |

## Verification
A load's write-back and the memory write of a store issued right behind it happen in the same cycle. The write-back comes from the read data of the earlier request, while the write port carries the new request. Directed load-then-store pairs provoke this, and so does the random stream, which issues a new instruction every cycle. In each such cycle the bench compares both the write-back outputs and the write port against its own predictions. The load's prediction is taken from the bench memory as it stood when the load was issued, so any mix-up between the two operations shows up.

// File: rtl/lsu64_pkg.sv
package lsu64_pkg;

  localparam int XLEN   = 64;
  localparam int NBYTES = XLEN / 8;
  localparam int OFS_W  = $clog2(NBYTES);
  localparam int IMM_W  = 12;
  localparam int REG_W  = 5;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_WORDU  = 3'b110;
  localparam logic [2:0] F3_DWORD  = 3'b011;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_WORDU = 2'd1,
    ACC_DLOAD = 2'd2,
    ACC_DSTOR = 2'd3
  } acc_kind_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [IMM_W-1:0] load_offset(input logic [31:0] ins);
    return ins[31:20];
  endfunction

  function automatic logic [IMM_W-1:0] store_offset(input logic [31:0] ins);
    return {ins[31:25], ins[11:7]};
  endfunction

  function automatic logic is_misaligned(input acc_kind_t k, input logic [OFS_W-1:0] lo);
    case (k)
      ACC_WORDU:            return lo[1:0] != 2'b00;
      ACC_DLOAD, ACC_DSTOR: return lo != '0;
      default:              return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] word_zext(input logic [XLEN-1:0] d, input logic hi);
    return hi ? {{(XLEN/2){1'b0}}, d[XLEN-1:XLEN/2]} : {{(XLEN/2){1'b0}}, d[XLEN/2-1:0]};
  endfunction

endpackage

// File: rtl/lsu64_decode.sv
module lsu64_decode
  import lsu64_pkg::*;
(
  input  logic              valid,
  input  logic [31:0]       ins,
  output acc_kind_t         kind,
  output logic [IMM_W-1:0]  offset,
  output logic [REG_W-1:0]  rd
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic       unused_rs_fields;

  assign opc = ins[6:0];
  assign f3  = ins[14:12];
  assign rd  = ins[11:7];
  assign unused_rs_fields = ^ins[19:15];

  always_comb begin
    kind   = ACC_NONE;
    offset = load_offset(ins);
    if (valid) begin
      if (opc == OPC_LOAD && f3 == F3_WORDU)       kind = ACC_WORDU;
      else if (opc == OPC_LOAD && f3 == F3_DWORD)  kind = ACC_DLOAD;
      else if (opc == OPC_STORE && f3 == F3_DWORD) begin
        kind   = ACC_DSTOR;
        offset = store_offset(ins);
      end
    end
  end

endmodule

// File: rtl/lsu64_agen.sv
module lsu64_agen
  import lsu64_pkg::*;
(
  input  acc_kind_t         kind,
  input  logic [XLEN-1:0]   base,
  input  logic [IMM_W-1:0]  offset,
  output logic [XLEN-1:0]   addr,
  output logic              mis
);

  assign addr = base + sext_imm(offset);
  assign mis  = is_misaligned(kind, addr[OFS_W-1:0]);

endmodule

// File: rtl/lsu64_wback.sv
module lsu64_wback
  import lsu64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_word,
  input  logic              cap_hi,
  input  logic [REG_W-1:0]  cap_rd,
  input  logic [XLEN-1:0]   rdata,
  output logic              wb_en,
  output logic [REG_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data
);

  logic             pend_en;
  logic             pend_word;
  logic             pend_hi;
  logic [REG_W-1:0] pend_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en   <= 1'b0;
      pend_word <= 1'b0;
      pend_hi   <= 1'b0;
      pend_rd   <= '0;
    end else begin
      pend_en   <= cap_en;
      pend_word <= cap_word;
      pend_hi   <= cap_hi;
      pend_rd   <= cap_rd;
    end
  end

  assign wb_en   = pend_en;
  assign wb_idx  = pend_en ? pend_rd : '0;
  assign wb_data = !pend_en ? '0 : (pend_word ? word_zext(rdata, pend_hi) : rdata);

  // R7: register zero is never written
  p_no_x0_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != '0);

  // R4: an unsigned word result has a clear upper half
  p_word_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && pend_word) |-> wb_data[XLEN-1:XLEN/2] == '0);

endmodule

// File: rtl/lsu64_unit.sv
module lsu64_unit
  import lsu64_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       instr,
  input  logic [63:0]       base_val,
  input  logic [63:0]       src2_val,
  output logic [63:0]       mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              misalign,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [63:0]       wb_data
);

  acc_kind_t        kind;
  logic [IMM_W-1:0] offset;
  logic [REG_W-1:0] rd;
  logic [XLEN-1:0]  ea;
  logic             ea_mis;
  logic             is_load;
  logic             store_fire;
  logic             load_fire;

  lsu64_decode u_dec (
    .valid  (req_valid),
    .ins    (instr),
    .kind   (kind),
    .offset (offset),
    .rd     (rd)
  );

  lsu64_agen u_agen (
    .kind   (kind),
    .base   (base_val),
    .offset (offset),
    .addr   (ea),
    .mis    (ea_mis)
  );

  assign is_load    = (kind == ACC_WORDU) || (kind == ACC_DLOAD);
  assign store_fire = (kind == ACC_DSTOR) && !ea_mis;
  assign load_fire  = is_load && !ea_mis && (rd != '0);

  assign mem_addr  = ea;
  assign mem_we    = store_fire;
  assign mem_be    = store_fire ? {NBYTES{1'b1}} : '0;
  assign mem_wdata = src2_val;
  assign misalign  = ea_mis;

  lsu64_wback u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (load_fire),
    .cap_word (kind == ACC_WORDU),
    .cap_hi   (ea[2]),
    .cap_rd   (rd),
    .rdata    (mem_rdata),
    .wb_en    (wb_en),
    .wb_idx   (wb_idx),
    .wb_data  (wb_data)
  );

  // R8: a memory write always goes to an aligned doubleword and is never flagged
  p_write_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[OFS_W-1:0] == '0 && !misalign));

  // R8: a flagged access is followed by no register write
  p_mis_blocks_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !wb_en);

  // R9: a register write traces back to a valid, unflagged, non-store request
  p_wb_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ($past(req_valid) && !$past(misalign) && !$past(mem_we)));

  // R1: an idle cycle touches nothing
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_we && mem_be == '0 && !misalign));

endmodule

// File: tb/sim_lsu64_unit.sv
module sim_lsu64_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] base_val = '0;
  logic [63:0] src2_val = '0;
  logic [63:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        misalign;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] mem [32];

  logic        pend_en = 1'b0;
  logic [4:0]  pend_idx = '0;
  logic [63:0] pend_data = '0;
  string       pend_req = "R9";

  always #2 clk = ~clk;

  lsu64_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .base_val(base_val), .src2_val(src2_val), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .misalign(misalign), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // synchronous memory model: read returns the pre-write contents next cycle
  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[7:3]];
    if (mem_we) mem[mem_addr[7:3]] <= mem_wdata;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_load(input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [11:0] imm);
    return {imm, 5'd7, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] mk_store(input logic [11:0] imm, input logic [4:0] rs2);
    return {imm[11:5], rs2, 5'd9, 3'b011, imm[4:0], 7'b0100011};
  endfunction

  function automatic logic [63:0] offs64(input logic [11:0] imm);
    logic signed [63:0] t;
    t = $signed(imm);
    return t;
  endfunction

  task automatic step(input logic v, input logic [31:0] ins,
                      input logic [63:0] b, input logic [63:0] s2);
    logic is_lwu, is_ld, is_sd, mis;
    logic [11:0] imm;
    logic [63:0] ea, word;
    @(negedge clk);
    // write-back of the previous request (R9)
    check({pend_req, " wb_en"}, {63'd0, wb_en}, {63'd0, pend_en});
    check("R9 wb_idx", {59'd0, wb_idx}, {59'd0, pend_idx});
    check({pend_req, " wb_data"}, wb_data, pend_data);
    req_valid = v; instr = ins; base_val = b; src2_val = s2;
    is_lwu = v && ins[6:0] == 7'b0000011 && ins[14:12] == 3'b110;
    is_ld  = v && ins[6:0] == 7'b0000011 && ins[14:12] == 3'b011;
    is_sd  = v && ins[6:0] == 7'b0100011 && ins[14:12] == 3'b011;
    imm = is_sd ? {ins[31:25], ins[11:7]} : ins[31:20];
    ea  = b + offs64(imm);
    mis = (is_lwu && (ea % 4) != 0) || ((is_ld || is_sd) && (ea % 8) != 0);
    #1;
    check(is_sd ? "R3 addr" : "R2 addr", (is_lwu || is_ld || is_sd) ? mem_addr : 64'd0,
          (is_lwu || is_ld || is_sd) ? ea : 64'd0);
    check(mis ? "R8 misalign" : "R1 misalign", {63'd0, misalign}, {63'd0, mis});
    check(mis ? "R8 we" : "R6 we", {63'd0, mem_we}, {63'd0, is_sd && !mis});
    check("R6 be", {56'd0, mem_be}, (is_sd && !mis) ? 64'hFF : 64'h0);
    if (is_sd && !mis) check("R6 wdata", mem_wdata, s2);
    word = mem[ea[7:3]];
    pend_en = (is_lwu || is_ld) && !mis && ins[11:7] != 5'd0;
    pend_idx = pend_en ? ins[11:7] : 5'd0;
    pend_req = is_lwu ? "R4" : (is_ld ? "R5" : (mis ? "R8" : (is_sd ? "R6" : "R1")));
    if ((is_lwu || is_ld) && ins[11:7] == 5'd0) pend_req = "R7";
    if (!pend_en) pend_data = 64'd0;
    else if (is_ld) pend_data = word;
    else pend_data = ea[2] ? (word >> 32) : (word & 64'h0000_0000_FFFF_FFFF);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++)
      mem[i] = {32'hA5000000 + 32'(i) * 32'h01010101, 32'hF0000000 ^ (32'(i) * 32'h00123457)};
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R10 wb_en in reset", {63'd0, wb_en}, 64'd0);
    check("R10 we in reset", {63'd0, mem_we}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 wb_en after reset", {63'd0, wb_en}, 64'd0);

    // directed corner cases
    step(1, mk_load(3'b011, 5'd3, 12'h010), 64'h0, 64'h0);        // R5 aligned dword
    step(1, mk_load(3'b110, 5'd4, 12'h000), 64'h20, 64'h0);       // R4 lower half
    step(1, mk_load(3'b110, 5'd5, 12'h004), 64'h20, 64'h0);       // R4 upper half, top bit set
    step(1, mk_load(3'b011, 5'd6, 12'hFF8), 64'h48, 64'h0);       // R2 negative offset
    step(1, mk_store(12'h7F8, 5'd2), 64'hFFFF_FFFF_FFFF_F8C0, 64'h0123_4567_89AB_CDEF); // R3 R6
    step(1, mk_load(3'b011, 5'd7, 12'h7F8), 64'hFFFF_FFFF_FFFF_F8C0, 64'h0); // read it back
    step(1, mk_store(12'hFE0, 5'd1), 64'h60, 64'hDEAD_BEEF_0000_1111); // store, negative split imm
    step(1, mk_load(3'b011, 5'd8, 12'h004), 64'h0, 64'h0);        // R8 dword off by 4
    step(1, mk_load(3'b110, 5'd9, 12'h002), 64'h0, 64'h0);        // R8 word off by 2
    step(1, mk_store(12'h001, 5'd3), 64'h10, 64'h5555);           // R8 store off by 1
    step(1, mk_load(3'b011, 5'd0, 12'h008), 64'h0, 64'h0);        // R7 rd zero
    step(1, mk_load(3'b010, 5'd10, 12'h008), 64'h0, 64'h0);       // R1 signed word load ignored
    step(1, {12'h008, 5'd1, 3'b011, 5'd11, 7'b0010011}, 64'h0, 64'h0); // R1 other opcode
    step(0, mk_store(12'h0, 5'd1), 64'h0, 64'h1);                 // R1 valid low
    step(1, mk_load(3'b011, 5'd12, 12'h000), 64'h30, 64'h0);      // load then store: same cycle
    step(1, mk_store(12'h000, 5'd4), 64'h30, 64'h7777_8888_9999_AAAA);
    step(1, mk_load(3'b110, 5'd13, 12'h004), 64'h30, 64'h0);      // R4 upper half of new data

    // constrained random stream
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [11:0] imm;
      logic [63:0] b, e;
      logic [4:0] rd;
      sel = $urandom % 6;
      imm = 12'($urandom);
      b   = {$urandom, $urandom};
      rd  = 5'($urandom);
      if (($urandom % 4) != 0) begin
        e = b + offs64(imm);
        b = b - (e & ((sel == 0) ? 64'd3 : 64'd7));
      end
      case (sel)
        0:       step(1, mk_load(3'b110, rd, imm), b, 64'h0);
        1, 2:    step(1, mk_load(3'b011, rd, imm), b, 64'h0);
        3:       step(1, mk_store(imm, rd), b, {$urandom, $urandom});
        4:       step(1, $urandom, b, {$urandom, $urandom});
        default: step(0, mk_load(3'b011, rd, imm), b, 64'h0);
      endcase
    end
    step(0, 32'h0, 64'h0, 64'h0);
    step(0, 32'h0, 64'h0, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule